// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Counter Timer

This block holds three independent 32-bit down-counters behind a small word-addressed register bus. Each channel has a live count, a reload constant and a control word. A shared start register holds one run bit per channel. A running channel counts once for every 4, 16, 64 or 256 pulses of a peripheral clock enable. It selects that rate with its own two-bit prescaler code.

When a running channel is at zero and its next count step arrives, it loads its reload constant, not all ones. It also sets a sticky wrap flag. The channel requests an interrupt while that flag and its interrupt enable are both set. Software acknowledges the request by writing the control word with the flag bit at 0. A combined output also reports whether any channel requests service, together with an event code for the lowest-numbered requesting channel. The codes start at a base value and step by 0x20 per channel.

The register bus is a plain single-cycle control path. A write is taken on the clock edge where select and write are both high. Read data is combinational from the address while select is high and write is low. The bus has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tri_timer`

## Requirements
- R1: After reset every counter and every reload constant reads 0xFFFFFFFF, the start register and all control words read 0, and no interrupt output is high.
- R2: Bit i of the start register (word offset 0, bits [2:0]) runs channel i; a channel whose bit is 0 keeps its count whatever happens on the peripheral clock enable, and its prescaler restarts from zero.
- R3: Control bits [1:0] select the rate: code 0, 1, 2, 3 gives one decrement per 4, 16, 64, 256 enable pulses; after a start the first decrement comes with exactly that many pulses.
- R4: A count step that finds the counter at 0 loads the reload constant (not 0xFFFFFFFF) and sets the wrap flag, control bit 7.
- R5: Interrupt line i is high exactly while channel i has both its wrap flag (bit 7) and its interrupt enable (control bit 4) set; the flag is set even when the enable is 0.
- R6: Writing a control word with bit 7 at 0 clears the wrap flag and drops the request; writing bit 7 as 1 never sets it; a wrap in the same cycle as a clearing write leaves the flag set.
- R7: A bus write to a counter takes effect at that clock edge and overrides a decrement or reload due in the same cycle.
- R8: Control bits other than 0, 1, 4 and 7, and start register bits above 2, read back as 0 and are ignored when written.
- R9: irq_any is high when any interrupt line is high; irq_code then equals 0x400 + 0x20 * i for the lowest-numbered requesting channel i, and is 0 otherwise.
- R10: Channel i uses word offsets 4(i+1) for the counter, 4(i+1)+1 for the reload constant and 4(i+1)+2 for the control word; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en | input | 1 | Peripheral clock enable pulse, one per prescaler input tick |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 3 | Per-channel interrupt request |
| irq_any | output | 1 | Any channel requests service |
| irq_code | output | 12 | Event code of lowest-numbered requesting channel |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is a software write to a counter and a decrement by the prescaler. The second is an acknowledging control write and a wrap that sets the flag again. The bench starts a channel at divide-by-4, gives exactly three enable pulses, and on the fourth pulse issues the bus write in the same cycle. It then judges that the written counter value survives intact, and that the flag reads back set with the counter at its reload value.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  // Control word bit positions visible to software
  localparam int CTRL_IE_BIT   = 4;
  localparam int CTRL_FLAG_BIT = 7;

  // Prescaler counter wide enough for the largest divider (256)
  localparam int PRE_W = 8;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [1:0] psel;
  } ctrl_t;

  // Terminal value of the prescaler for a rate code: 4 << (2*code) minus one
  function automatic logic [PRE_W-1:0] presc_limit(input logic [1:0] code);
    case (code)
      2'd0:    presc_limit = PRE_W'(3);
      2'd1:    presc_limit = PRE_W'(15);
      2'd2:    presc_limit = PRE_W'(63);
      default: presc_limit = PRE_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/tri_timer_presc.sv
module tri_timer_presc
  import tri_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pclk_en,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] limit;

  assign limit = presc_limit(psel);
  // ">=" lets a lowered rate code take effect without waiting for a wrap
  assign tick  = run && pclk_en && (pcnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (!run)    pcnt_q <= '0;
    else if (tick)    pcnt_q <= '0;
    else if (pclk_en) pcnt_q <= pcnt_q + PRE_W'(1);
  end

endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_reload,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output ctrl_t            ctrl_q,
  output logic             irq
);

  logic wrap;

  assign wrap = tick && (cnt_q == '0);
  assign irq  = ctrl_q.flag && ctrl_q.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_cnt)    cnt_q <= wdata;
      else if (wrap) cnt_q <= reload_q;
      else if (tick) cnt_q <= cnt_q - CNT_W'(1);

      if (wr_reload) reload_q <= wdata;

      if (wr_ctrl) begin
        ctrl_q.psel <= wdata[1:0];
        ctrl_q.ie   <= wdata[CTRL_IE_BIT];
      end

      if (wrap)                                  ctrl_q.flag <= 1'b1;
      else if (wr_ctrl && !wdata[CTRL_FLAG_BIT]) ctrl_q.flag <= 1'b0;
    end
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !wr_cnt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R4
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !wr_cnt && !wr_reload) |=> (cnt_q == $past(reload_q)));

  // R4
  flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0) |=> ctrl_q.flag);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CTRL_FLAG_BIT] && !(tick && cnt_q == '0)) |=> !ctrl_q.flag);

  // R7
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/tri_timer_irqsel.sv
module tri_timer_irqsel #(
  parameter int          CH_N     = 3,
  parameter int          CODE_W   = 12,
  parameter int unsigned EVT_BASE = 32'h400,
  parameter int unsigned EVT_STEP = 32'h20
) (
  input  logic [CH_N-1:0]   irq,
  output logic              irq_any,
  output logic [CODE_W-1:0] irq_code
);

  always_comb begin
    irq_code = '0;
    // Scan downward so the lowest-numbered requester is assigned last
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (irq[i]) irq_code = CODE_W'(EVT_BASE + EVT_STEP * i);
    end
  end

  assign irq_any = |irq;

  // R9
  code_idle_chk: assert final (irq_any || irq_code == '0);

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int          CH_N     = 3,
  parameter int          CNT_W    = 32,
  parameter int          ADDR_W   = 4,
  parameter int          CODE_W   = 12,
  parameter int unsigned EVT_BASE = 32'h400,
  parameter int unsigned EVT_STEP = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [CH_N-1:0]   irq,
  output logic              irq_any,
  output logic [CODE_W-1:0] irq_code
);

  localparam logic [ADDR_W-1:0] START_OFS = '0;
  localparam int                BLK_WORDS = 4;

  logic             wr_en;
  logic [CH_N-1:0]  start_q;
  logic [CH_N-1:0]  wr_cnt, wr_reload, wr_ctrl, tick;
  logic [CNT_W-1:0] cnt_all    [CH_N];
  logic [CNT_W-1:0] reload_all [CH_N];
  ctrl_t            ctrl_all   [CH_N];

  assign wr_en = bus_sel && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              start_q <= '0;
    else if (wr_en && bus_addr == START_OFS) start_q <= bus_wdata[CH_N-1:0];
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((g + 1) * BLK_WORDS);

    assign wr_cnt[g]    = wr_en && (bus_addr == BASE);
    assign wr_reload[g] = wr_en && (bus_addr == BASE + ADDR_W'(1));
    assign wr_ctrl[g]   = wr_en && (bus_addr == BASE + ADDR_W'(2));

    tri_timer_presc u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_q[g]),
      .pclk_en (pclk_en),
      .psel    (ctrl_all[g].psel),
      .tick    (tick[g])
    );

    tri_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (start_q[g]),
      .tick      (tick[g]),
      .wr_cnt    (wr_cnt[g]),
      .wr_reload (wr_reload[g]),
      .wr_ctrl   (wr_ctrl[g]),
      .wdata     (bus_wdata),
      .cnt_q     (cnt_all[g]),
      .reload_q  (reload_all[g]),
      .ctrl_q    (ctrl_all[g]),
      .irq       (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == START_OFS) bus_rdata[CH_N-1:0] = start_q;
      for (int g = 0; g < CH_N; g++) begin
        if (bus_addr == ADDR_W'((g + 1) * BLK_WORDS))
          bus_rdata = cnt_all[g];
        if (bus_addr == ADDR_W'((g + 1) * BLK_WORDS + 1))
          bus_rdata = reload_all[g];
        if (bus_addr == ADDR_W'((g + 1) * BLK_WORDS + 2)) begin
          bus_rdata[1:0]           = ctrl_all[g].psel;
          bus_rdata[CTRL_IE_BIT]   = ctrl_all[g].ie;
          bus_rdata[CTRL_FLAG_BIT] = ctrl_all[g].flag;
        end
      end
    end
  end

  tri_timer_irqsel #(
    .CH_N     (CH_N),
    .CODE_W   (CODE_W),
    .EVT_BASE (EVT_BASE),
    .EVT_STEP (EVT_STEP)
  ) u_irqsel (
    .irq      (irq),
    .irq_any  (irq_any),
    .irq_code (irq_code)
  );

  // R2
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tick & start_q) || ((tick & ~start_q) == '0));

  // R6
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl[0] && !bus_wdata[CTRL_FLAG_BIT] && !tick[0]) |=> !irq[0]);

endmodule

// File: tb/tb_tri_timer.sv
module tb_tri_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pclk_en;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  logic        irq_any;
  logic [11:0] irq_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tri_timer dut (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_any(irq_any), .irq_code(irq_code)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      pclk_en = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    pclk_en = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 3; c++) begin
      expect_rd("R1 counter", 4'((c + 1) * 4), 32'hFFFF_FFFF);
      expect_rd("R1 reload", 4'((c + 1) * 4 + 1), 32'hFFFF_FFFF);
      expect_rd("R1 control", 4'((c + 1) * 4 + 2), 32'h0);
    end
    expect_rd("R1 start", 4'd0, 32'h0);
    check("R1 irq", {28'h0, irq_any, irq}, 32'h0);
  endtask

  task automatic t_prescale;
    for (int c = 0; c < 4; c++) begin
      int div = 4 << (2 * c);
      wr(0, 0); wr(4, 100); wr(6, c); wr(0, 1);
      pulse(div - 1);
      expect_rd("R3 before first step", 4, 100);
      pulse(1);
      expect_rd("R3 first step", 4, 99);
      pulse(2 * div);
      expect_rd("R3 steady rate", 4, 97);
      wr(0, 0);
    end
    expect_rd("R2 never started", 8, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold;
    wr(8, 50); wr(10, 0); wr(0, 2);
    pulse(4);
    expect_rd("R2 running", 8, 49);
    wr(0, 0);
    pulse(20);
    expect_rd("R2 stopped holds", 8, 49);
  endtask

  task automatic t_wrap;
    wr(0, 0); wr(5, 5); wr(4, 1); wr(6, 32'h10); wr(0, 1);
    pulse(4);
    expect_rd("R4 at zero", 4, 0);
    expect_rd("R4 no flag yet", 6, 32'h10);
    check("R5 no irq yet", {29'h0, irq}, 0);
    pulse(4);
    expect_rd("R4 reload", 4, 5);
    expect_rd("R4 flag set", 6, 32'h90);
    check("R5 irq0", {29'h0, irq}, 32'h1);
    check("R9 any", {31'h0, irq_any}, 1);
    check("R9 code ch0", {20'h0, irq_code}, 32'h400);
    pulse(4);
    expect_rd("R4 counts on", 4, 4);
    expect_rd("R6 sticky", 6, 32'h90);
    wr(0, 0);
  endtask

  task automatic t_ack;
    wr(6, 32'h90);
    expect_rd("R6 write one keeps", 6, 32'h90);
    wr(6, 32'h10);
    expect_rd("R6 cleared", 6, 32'h10);
    check("R6 irq dropped", {28'h0, irq_any, irq}, 0);
    wr(6, 32'h90);
    expect_rd("R6 write one no set", 6, 32'h10);
  endtask

  task automatic t_gate_and_priority;
    wr(14, 0); wr(12, 0); wr(13, 9); wr(0, 4);
    pulse(4);
    expect_rd("R4 ch2 reload", 12, 9);
    expect_rd("R5 flag without enable", 14, 32'h80);
    check("R5 gated", {29'h0, irq}, 0);
    wr(14, 32'h90);
    check("R5 enabled", {29'h0, irq}, 32'h4);
    check("R9 code ch2", {20'h0, irq_code}, 32'h440);
    wr(0, 0);
    wr(10, 32'h10); wr(8, 0); wr(9, 3); wr(0, 2);
    pulse(4);
    check("R9 two requesters", {29'h0, irq}, 32'h6);
    check("R9 lowest wins", {20'h0, irq_code}, 32'h420);
    wr(10, 32'h10);
    check("R9 next requester", {20'h0, irq_code}, 32'h440);
    wr(14, 0);
    check("R9 none", {19'h0, irq_any, irq_code}, 0);
    wr(0, 0);
  endtask

  task automatic t_collide_write;
    wr(0, 0); wr(4, 500); wr(6, 0); wr(0, 1);
    pulse(3);
    expect_rd("R7 pre", 4, 500);
    pclk_en = 1'b1;
    wr(4, 1000);
    pclk_en = 1'b0;
    expect_rd("R7 write beats step", 4, 1000);
    pulse(4);
    expect_rd("R7 steps after", 4, 999);
    wr(0, 0);
  endtask

  task automatic t_collide_ack;
    wr(6, 32'h10); wr(5, 7); wr(4, 0); wr(0, 1);
    pulse(4);
    expect_rd("R4 wrap", 6, 32'h90);
    wr(4, 0);
    pulse(3);
    pclk_en = 1'b1;
    wr(6, 32'h10);
    pclk_en = 1'b0;
    expect_rd("R6 wrap beats ack", 6, 32'h90);
    expect_rd("R4 reload on collide", 4, 7);
    check("R6 irq stays", {29'h0, irq}, 32'h1);
    wr(0, 0);
    wr(6, 32'h10);
    expect_rd("R6 final ack", 6, 32'h10);
  endtask

  task automatic t_reserved;
    wr(6, 32'hFFFF_FF73);
    expect_rd("R8 control mask", 6, 32'h13);
    wr(0, 32'hFFFF_FFF8);
    expect_rd("R8 start mask", 0, 0);
    expect_rd("R10 hole 3", 3, 0);
    expect_rd("R10 hole 7", 7, 0);
    expect_rd("R10 hole 15", 15, 0);
    wr(9, 32'h1234_5678);
    expect_rd("R10 ch1 reload offset", 9, 32'h1234_5678);
    expect_rd("R10 ch0 reload untouched", 5, 7);
  endtask

  initial begin
    rst_n = 1'b0; pclk_en = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_hold();
    t_wrap();
    t_ack();
    t_gate_and_priority();
    t_collide_write();
    t_collide_ack();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule